// File: doc/BRIEF.md
# Register-Access Command Port

This block lets a host reach a remote 16-bit register space through a single command register. One 32-bit write to that register starts one transaction. The word carries a direction flag, a halfword address and the data for a write. A backend engine, seen here as a request/acknowledge interface, performs the transaction. A small state machine steps through the transaction, and its current state appears in a status word that the host polls.

A write transaction finishes as soon as the backend accepts it. A read transaction waits for the backend to return data. It then keeps that data parked in the status word until the host acknowledges it by writing a valid-clear register. A sticky init-done flag, which only software sets, is also shown in the status word. Hosts use it to tell whether the link has been brought up.

The backend request follows a hold-until-accepted rule. Once raised, `be_req` stays high and the direction, address and data stay frozen until the backend asserts `be_ack`. The backend applies back-pressure simply by holding `be_ack` low. Read data is taken in the first cycle in which `be_rvalid` is high while the machine waits for it.

Top module: `regwrap_cmd_port`

## Requirements
- R1: A command word (host_sel = 0) splits into three fields: bit 31 is the direction (1 write, 0 read), bits 30:16 are the halfword address, and bits 15:0 are the write data. While the request is raised, these fields appear on be_we, be_addr and be_wdata.
- R2: A command accepted in the idle state moves the machine to the request state on the next clock. There be_req is high, and be_we, be_addr and be_wdata stay constant until be_ack.
- R3: In the request state, be_ack on a write returns the machine to idle on the next clock, with no valid-clear needed.
- R4: In the request state, be_ack on a read moves the machine to the data-wait state. In the data-wait state, be_rvalid captures be_rdata and moves the machine to the parked state.
- R5: In the parked state, the state and the read-data field do not change until a valid-clear write (host_sel = 1, bit 0 = 1), which returns the machine to idle on the next clock.
- R6: A command written while the state is not idle is dropped: the state does not change and no new backend request is started.
- R7: A valid-clear write has no effect in any state other than parked. A valid-clear write with bit 0 = 0 has no effect in any state.
- R8: Status bits 15:0 hold the most recently captured read data. Bits 18:16 hold the state (idle 0, request 1, data-wait 2, parked 3). Bit 20 is sync-idle, which is 1 in idle and parked, when no backend transaction is in flight. Bit 21 is init-done. All other bits are 0.
- R9: Init-done is 0 after reset. A write with host_sel = 2 and bit 0 = 1 sets it. A later write of 0 does not clear it.
- R10: After reset, the status word is 0x00100000 and be_req is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_sel | input | 2 | Register select: 0 command, 1 valid-clear, 2 init-done |
| host_wdata | input | 32 | Host write data |
| status | output | 32 | Status word |
| be_req | output | 1 | Backend request, held until be_ack |
| be_we | output | 1 | Backend direction, 1 = write |
| be_addr | output | 15 | Backend halfword address |
| be_wdata | output | 16 | Backend write data |
| be_ack | input | 1 | Backend accepts the request |
| be_rvalid | input | 1 | Backend read data valid |
| be_rdata | input | 16 | Backend read data |

## Verification
The bench injects a second command while the request is pending and again while a read is parked. A port that failed to drop commands would overwrite be_addr or restart the request. It issues valid-clear writes in idle, in the data-wait state, and with bit 0 cleared while parked. A design that decoded loosely would drop the parked data or jump states early. It holds be_ack low for random spans to confirm that the request fields stay frozen. It also drives junk on be_rdata outside rvalid: a design that sampled the bus at the wrong time would show the wrong value in status bits 15:0. Init-done is written 1 and then 0, to catch a flag that simply follows the last write.

// File: rtl/regwrap_pkg.sv
package regwrap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_REQ    = 3'd1,
    ST_WFDATA = 3'd2,
    ST_PARKED = 3'd3
  } wst_e;

  localparam logic [1:0] SEL_CMD  = 2'd0;
  localparam logic [1:0] SEL_VCLR = 2'd1;
  localparam logic [1:0] SEL_INIT = 2'd2;
endpackage

// File: rtl/regwrap_cmd_decode.sv
module regwrap_cmd_decode #(
  parameter int CMD_W  = 32,
  parameter int ADDR_W = 15,
  parameter int DATA_W = 16
) (
  input  logic [CMD_W-1:0]  cmd,
  output logic              dec_we,
  output logic [ADDR_W-1:0] dec_addr,
  output logic [DATA_W-1:0] dec_wdata
);
  localparam int ADDR_LSB = DATA_W;
  localparam int WE_BIT   = CMD_W - 1;

  always_comb begin
    dec_we    = cmd[WE_BIT];
    dec_addr  = cmd[ADDR_LSB +: ADDR_W];
    dec_wdata = cmd[DATA_W-1:0];
  end
endmodule

// File: rtl/regwrap_fsm.sv
module regwrap_fsm
  import regwrap_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_fire,
  input  logic              vclr_fire,
  input  logic              dec_we,
  input  logic [ADDR_W-1:0] dec_addr,
  input  logic [DATA_W-1:0] dec_wdata,
  input  logic              be_ack,
  input  logic              be_rvalid,
  input  logic [DATA_W-1:0] be_rdata,
  output wst_e              state,
  output logic [DATA_W-1:0] rd_hold,
  output logic              be_req,
  output logic              be_we,
  output logic [ADDR_W-1:0] be_addr,
  output logic [DATA_W-1:0] be_wdata
);
  wst_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      be_we    <= 1'b0;
      be_addr  <= '0;
      be_wdata <= '0;
      rd_hold  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (cmd_fire) begin
          state_q  <= ST_REQ;
          be_we    <= dec_we;
          be_addr  <= dec_addr;
          be_wdata <= dec_wdata;
        end
        ST_REQ: if (be_ack) state_q <= be_we ? ST_IDLE : ST_WFDATA;
        ST_WFDATA: if (be_rvalid) begin
          rd_hold <= be_rdata;
          state_q <= ST_PARKED;
        end
        ST_PARKED: if (vclr_fire) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state  = state_q;
  assign be_req = (state_q == ST_REQ);
endmodule

// File: rtl/regwrap_status.sv
module regwrap_status
  import regwrap_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int STAT_W = 32
) (
  input  wst_e              state,
  input  logic [DATA_W-1:0] rd_hold,
  input  logic              init_done,
  output logic [STAT_W-1:0] status
);
  localparam int ST_LSB   = DATA_W;
  localparam int SYNC_BIT = DATA_W + 4;
  localparam int INIT_BIT = DATA_W + 5;

  logic sync_idle;
  assign sync_idle = (state == ST_IDLE) || (state == ST_PARKED);

  always_comb begin
    status                 = '0;
    status[DATA_W-1:0]     = rd_hold;
    status[ST_LSB +: 3]    = state;
    status[SYNC_BIT]       = sync_idle;
    status[INIT_BIT]       = init_done;
  end
endmodule

// File: rtl/regwrap_cmd_port.sv
module regwrap_cmd_port
  import regwrap_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     host_wr,
  input  logic [1:0]               host_sel,
  input  logic [ADDR_W+DATA_W:0]   host_wdata,
  output logic [ADDR_W+DATA_W:0]   status,
  output logic                     be_req,
  output logic                     be_we,
  output logic [ADDR_W-1:0]        be_addr,
  output logic [DATA_W-1:0]        be_wdata,
  input  logic                     be_ack,
  input  logic                     be_rvalid,
  input  logic [DATA_W-1:0]        be_rdata
);
  localparam int CMD_W = ADDR_W + DATA_W + 1;

  wst_e              state;
  logic [DATA_W-1:0] rd_hold;
  logic              dec_we;
  logic [ADDR_W-1:0] dec_addr;
  logic [DATA_W-1:0] dec_wdata;
  logic              init_done;
  logic              cmd_fire, vclr_fire, init_fire;

  assign cmd_fire  = host_wr && (host_sel == SEL_CMD);
  assign vclr_fire = host_wr && (host_sel == SEL_VCLR) && host_wdata[0];
  assign init_fire = host_wr && (host_sel == SEL_INIT) && host_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         init_done <= 1'b0;
    else if (init_fire) init_done <= 1'b1;
  end

  regwrap_cmd_decode #(.CMD_W(CMD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dec (
    .cmd(host_wdata), .dec_we(dec_we), .dec_addr(dec_addr), .dec_wdata(dec_wdata)
  );

  regwrap_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_fire(cmd_fire), .vclr_fire(vclr_fire),
    .dec_we(dec_we), .dec_addr(dec_addr), .dec_wdata(dec_wdata),
    .be_ack(be_ack), .be_rvalid(be_rvalid), .be_rdata(be_rdata),
    .state(state), .rd_hold(rd_hold), .be_req(be_req), .be_we(be_we),
    .be_addr(be_addr), .be_wdata(be_wdata)
  );

  regwrap_status #(.DATA_W(DATA_W), .STAT_W(CMD_W)) i_stat (
    .state(state), .rd_hold(rd_hold), .init_done(init_done), .status(status)
  );
endmodule

// File: rtl/regwrap_cmd_port_chk.sv
module regwrap_cmd_port_chk #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   host_wr,
  input logic [1:0]             host_sel,
  input logic [ADDR_W+DATA_W:0] host_wdata,
  input logic [ADDR_W+DATA_W:0] status,
  input logic                   be_req,
  input logic                   be_we,
  input logic [ADDR_W-1:0]      be_addr,
  input logic [DATA_W-1:0]      be_wdata,
  input logic                   be_ack,
  input logic                   be_rvalid,
  input logic [DATA_W-1:0]      be_rdata
);
  localparam int TOP = ADDR_W + DATA_W;
  logic [2:0] st;
  logic       cmd_w, vclr1;
  assign st    = status[DATA_W +: 3];
  assign cmd_w = host_wr && host_sel == 2'd0;
  assign vclr1 = host_wr && host_sel == 2'd1 && host_wdata[0];

  AST_CMD_TO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    st == 3'd0 && cmd_w |=> st == 3'd1 && be_req && be_we == $past(host_wdata[TOP])
      && be_addr == $past(host_wdata[DATA_W +: ADDR_W]) && be_wdata == $past(host_wdata[DATA_W-1:0])); // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    be_req && !be_ack |=> be_req && $stable(be_we) && $stable(be_addr) && $stable(be_wdata)); // R2
  AST_WRITE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    be_req && be_ack && be_we |=> st == 3'd0); // R3
  AST_READ_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    be_req && be_ack && !be_we |=> st == 3'd2 && !be_req); // R4
  AST_DATA_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    st == 3'd3 && !vclr1 |=> st == 3'd3 && $stable(status[DATA_W-1:0])); // R5
  AST_CMD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    st == 3'd2 && cmd_w && !be_rvalid |=> st == 3'd2 && $stable(be_addr) && !be_req); // R6
  AST_VCLR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    st == 3'd2 && vclr1 && !be_rvalid |=> st == 3'd2); // R7
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status[TOP:DATA_W+6] == '0 && status[DATA_W+3] == 1'b0); // R8
  AST_INIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    status[DATA_W+5] |=> status[DATA_W+5]); // R9
endmodule

bind regwrap_cmd_port regwrap_cmd_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_regwrap_cmd_port.sv
module test_regwrap_cmd_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] status;
  logic        be_req, be_we;
  logic [14:0] be_addr;
  logic [15:0] be_wdata;
  logic        be_ack = 1'b0;
  logic        be_rvalid = 1'b0;
  logic [15:0] be_rdata = '0;

  int checks = 0;
  int fails = 0;
  logic [15:0] last_rd = '0;
  logic        init_exp = 1'b0;

  always #5 clk = ~clk;

  regwrap_cmd_port i_regwrap_cmd_port (.*);

  function automatic logic [31:0] stat(input logic [15:0] d, input logic [2:0] s, input logic ini);
    logic sync = (s == 3'd0) || (s == 3'd3);
    return {10'b0, ini, sync, 1'b0, s, d};
  endfunction

  function automatic logic [15:0] remote_val(input logic [14:0] a);
    return 16'(({1'b0, a} * 16'h9e37) ^ 16'h5a5a);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic hw(input logic [1:0] sel, input logic [31:0] d);
    host_wr = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0; host_wdata = $urandom;
  endtask

  task automatic txn(input logic we, input logic [14:0] a, input logic [15:0] wd,
                     input int dly_ack, input int dly_rv, input bit inject);
    logic [15:0] v;
    hw(2'd0, {we, a, wd});
    chk(status == stat(last_rd, 3'd1, init_exp), "R2 request state", status, stat(last_rd, 3'd1, init_exp));
    chk(be_req && be_we == we && be_addr == a && be_wdata == wd, "R1 fields", {be_we, be_addr, be_wdata}, {we, a, wd});
    if (inject) begin
      hw(2'd0, {~we, ~a, ~wd});
      chk(status[18:16] == 3'd1 && be_addr == a && be_we == we, "R6 drop in request", {13'b0, status[18:16], be_addr}, {13'b0, 3'd1, a});
    end
    for (int i = 0; i < dly_ack; i++) begin
      @(negedge clk);
      chk(be_req && be_addr == a && be_wdata == wd, "R2 hold", {be_req, be_addr, be_wdata}, {1'b1, a, wd});
    end
    be_ack = 1'b1; @(negedge clk); be_ack = 1'b0;
    if (we) begin
      chk(status == stat(last_rd, 3'd0, init_exp) && !be_req, "R3 write done", status, stat(last_rd, 3'd0, init_exp));
      return;
    end
    chk(status == stat(last_rd, 3'd2, init_exp) && !be_req, "R4 data wait", status, stat(last_rd, 3'd2, init_exp));
    for (int i = 0; i < dly_rv; i++) @(negedge clk);
    if (inject) begin
      hw(2'd1, 32'h1);
      chk(status == stat(last_rd, 3'd2, init_exp), "R7 clear in data wait", status, stat(last_rd, 3'd2, init_exp));
    end
    v = remote_val(a);
    be_rdata = v; be_rvalid = 1'b1; @(negedge clk); be_rvalid = 1'b0; be_rdata = $urandom;
    last_rd = v;
    chk(status == stat(last_rd, 3'd3, init_exp), "R4 parked", status, stat(last_rd, 3'd3, init_exp));
    if (inject) begin
      hw(2'd1, 32'hffff_fffe);
      chk(status == stat(last_rd, 3'd3, init_exp), "R7 clear bit0 zero", status, stat(last_rd, 3'd3, init_exp));
      hw(2'd0, 32'h8000_1234);
      chk(status == stat(last_rd, 3'd3, init_exp) && !be_req, "R6 drop while parked", status, stat(last_rd, 3'd3, init_exp));
    end
    for (int i = 0; i < dly_rv; i++) @(negedge clk);
    chk(status == stat(last_rd, 3'd3, init_exp), "R5 data held", status, stat(last_rd, 3'd3, init_exp));
    hw(2'd1, 32'h1);
    chk(status == stat(last_rd, 3'd0, init_exp), "R5 clear to idle", status, stat(last_rd, 3'd0, init_exp));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status == 32'h0010_0000 && !be_req, "R10 reset", status, 32'h0010_0000);
    chk(status == stat(16'h0, 3'd0, 1'b0), "R8 idle layout", status, stat(16'h0, 3'd0, 1'b0));
    hw(2'd1, 32'h1);
    chk(status == stat(16'h0, 3'd0, 1'b0), "R7 clear in idle", status, stat(16'h0, 3'd0, 1'b0));
    hw(2'd2, 32'h0);
    chk(status[21] == 1'b0, "R9 zero write", {31'b0, status[21]}, 32'h0);
    txn(1'b0, 15'h7fff, 16'h0, 0, 0, 1'b1);
    txn(1'b1, 15'h0000, 16'hffff, 0, 0, 1'b1);
    hw(2'd2, 32'h1); init_exp = 1'b1;
    chk(status == stat(last_rd, 3'd0, 1'b1), "R9 set", status, stat(last_rd, 3'd0, 1'b1));
    hw(2'd2, 32'h0);
    chk(status[21] == 1'b1, "R9 sticky", {31'b0, status[21]}, 32'h1);
    for (int n = 0; n < 60; n++) begin
      txn(1'($urandom), 15'($urandom), 16'($urandom), int'($urandom % 4),
          int'($urandom % 4), ($urandom % 3) == 0);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule